// File: doc/BRIEF.md
# Interrupt Request Collector and Pin Driver

This block gathers eight event-request flags into a byte, masks them through a per-flag enable register and a master enable, and drives one interrupt pin. Each source pulses its event input for one cycle. The matching flag then stays set until the register port writes a 1 to that bit position. The flag byte goes out as a port so that the serial interface can shift it out as status.

The pin has two modes. In level mode it behaves as open-drain and active low. It pulls low whenever an enabled flag is pending, and it releases to high impedance otherwise. In edge mode it is push-pull with a programmable active level. When the set of enabled pending flags goes from empty to non-empty, the pin emits one active pulse of fixed length.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After synchronous reset, all flags and the flag mask are 0, the level-mode output enable is 0, and the edge pulse is idle.
- R2: When the event input for bit i is high at a clock edge, flag bit i reads 1 after that edge.
- R3: Writing with `clr_we` high clears every flag whose bit in `clr_data` is 1 at that edge. Flags whose clear bit is 0 are unaffected.
- R4: If a flag's set pulse and its clear arrive in the same cycle, the flag reads 1 afterwards.
- R5: Flag bit order, MSB to LSB: suspend, bus reset, setup available, IN3 buffer available, IN2 buffer available, OUT1 data available, OUT0 data available, IN0 buffer available. Bit i of `evt_pulse` sets bit i of `flags`.
- R6: The mask is loaded from `mask_data` when `mask_we` is high. A flag contributes to the pin only if its mask bit is 1.
- R7: In level mode (`mode_edge`=0) with `ie`=1, `pin_oe` is 1 and `pin_drv` is 0 exactly while some masked-in flag is set. Otherwise `pin_oe` is 0.
- R8: In edge mode (`mode_edge`=1), `pin_oe` stays 1. The pin sits at the inactive level (`~pol_high`) except during a pulse.
- R9: In edge mode with `ie`=1, a rising edge of the OR of masked-in pending flags makes `pin_drv` equal `pol_high` for exactly 4 cycles, starting at the next clock edge. A steady pending condition gives no further pulse.
- R10: With `ie`=0, level mode releases the pin (`pin_oe`=0) and edge mode holds the pin at its inactive level. The flags still set and clear normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 8 | One-cycle event pulses, one per flag |
| clr_we | input | 1 | Flag clear strobe |
| clr_data | input | 8 | Write-1-to-clear pattern |
| mask_we | input | 1 | Mask register write strobe |
| mask_data | input | 8 | New mask value |
| ie | input | 1 | Global interrupt enable |
| mode_edge | input | 1 | 0 = level/open-drain, 1 = edge/push-pull |
| pol_high | input | 1 | Edge-mode active level |
| flags | output | 8 | Pending flag byte (status byte) |
| pin_drv | output | 1 | Pin data value |
| pin_oe | output | 1 | Pin output enable |

## Verification
The bench targets a set and a clear of the same bit in one cycle; a design that gives the clear priority loses the event. It checks that a flag masked out cannot assert the pin. It also checks that a second flag arriving while one is pending produces no new edge-mode pulse; a design that detects per-flag edges would pulse twice. Pulse length is counted cycle by cycle, so an off-by-one counter is caught. Enable and mode are toggled to catch a level pin left driven while disabled, or an edge pin left floating.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;
    localparam int N_FLAGS   = 8;
    localparam int PULSE_LEN = 4;
    localparam int CNT_W     = $clog2(PULSE_LEN + 1);

    typedef enum logic [2:0] {
        B_IN0_BAV  = 3'd0,
        B_OUT0_DAV = 3'd1,
        B_OUT1_DAV = 3'd2,
        B_IN2_BAV  = 3'd3,
        B_IN3_BAV  = 3'd4,
        B_SETUP    = 3'd5,
        B_BUSRST   = 3'd6,
        B_SUSPEND  = 3'd7
    } flag_pos_e;

    typedef struct packed {
        logic drv;
        logic oe;
    } pin_t;

    function automatic logic any_pending(input logic [N_FLAGS-1:0] f,
                                         input logic [N_FLAGS-1:0] m);
        return |(f & m);
    endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pin_pkg::*;
#(
    parameter int W = N_FLAGS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    input  logic         mask_we,
    input  logic [W-1:0] mask_data,
    output logic [W-1:0] flags_o,
    output logic [W-1:0] mask_o
);
    for (genvar i = 0; i < W; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags_o[i] <= 1'b0;
            else if (set_i[i])
                flags_o[i] <= 1'b1;
            else if (clr_we && clr_data[i])
                flags_o[i] <= 1'b0;
        end

        p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> flags_o[i]);
        p_clear_r3: assert property (@(posedge clk) disable iff (rst)
            (clr_we && clr_data[i] && !set_i[i]) |=> !flags_o[i]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask_o <= '0;
        else if (mask_we)
            mask_o <= mask_data;
    end
endmodule

// File: rtl/irq_edge_pulser.sv
module irq_edge_pulser
    import irq_pin_pkg::*;
#(
    parameter int LEN = PULSE_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic active_o
);
    localparam int CW = $clog2(LEN + 1);

    logic          req_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            req_q <= req_i;
            if (req_i && !req_q)
                cnt_q <= CW'(LEN);
            else if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign active_o = (cnt_q != '0);

    p_pulse_start_r9: assert property (@(posedge clk) disable iff (rst)
        (req_i && !req_q) |=> active_o);
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
    import irq_pin_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [N_FLAGS-1:0] evt_pulse,
    input  logic               clr_we,
    input  logic [N_FLAGS-1:0] clr_data,
    input  logic               mask_we,
    input  logic [N_FLAGS-1:0] mask_data,
    input  logic               ie,
    input  logic               mode_edge,
    input  logic               pol_high,
    output logic [N_FLAGS-1:0] flags,
    output logic               pin_drv,
    output logic               pin_oe
);
    logic [N_FLAGS-1:0] mask;
    logic               pend;
    logic               pulse;
    pin_t               pin;

    irq_flag_bank #(.W(N_FLAGS)) u_bank (
        .clk(clk), .rst(rst), .set_i(evt_pulse),
        .clr_we(clr_we), .clr_data(clr_data),
        .mask_we(mask_we), .mask_data(mask_data),
        .flags_o(flags), .mask_o(mask)
    );

    assign pend = ie && any_pending(flags, mask);

    irq_edge_pulser #(.LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst(rst), .req_i(pend), .active_o(pulse)
    );

    always_comb begin
        if (mode_edge) begin
            pin.oe  = 1'b1;
            pin.drv = (pulse && ie) ? pol_high : ~pol_high;
        end else begin
            pin.oe  = pend;
            pin.drv = 1'b0;
        end
    end

    assign pin_drv = pin.drv;
    assign pin_oe  = pin.oe;

    p_level_off_r10: assert property (@(posedge clk) disable iff (rst)
        (!mode_edge && !ie) |-> !pin_oe);
    p_edge_oe_r8: assert property (@(posedge clk) disable iff (rst)
        mode_edge |-> pin_oe);
    p_masked_r6: assert property (@(posedge clk) disable iff (rst)
        (!mode_edge && ((flags & mask) == '0)) |-> !pin_oe);
endmodule

// File: tb/irq_pin_ctrl_tb_top.sv
module irq_pin_ctrl_tb_top;
    logic clk = 0, rst = 1;
    logic [7:0] evt_pulse = 0, clr_data = 0, mask_data = 0;
    logic clr_we = 0, mask_we = 0, ie = 0, mode_edge = 0, pol_high = 0;
    logic [7:0] flags;
    logic pin_drv, pin_oe;

    int n_chk = 0, n_fail = 0;
    logic [7:0] m_flags = 0, m_mask = 0;
    logic m_pend_q = 0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    irq_pin_ctrl dut_i (.*);

    // reference model: advances at each edge from the inputs seen there
    always @(posedge clk) begin
        logic pend_now;
        if (rst) begin
            m_flags = 0; m_mask = 0; m_pend_q = 0; m_cnt = 0;
        end else begin
            pend_now = ie && ((m_flags & m_mask) != 0);
            if (pend_now && !m_pend_q) m_cnt = 4;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            m_pend_q = pend_now;
            for (int i = 0; i < 8; i++) begin
                if (evt_pulse[i]) m_flags[i] = 1;
                else if (clr_we && clr_data[i]) m_flags[i] = 0;
            end
            if (mask_we) m_mask = mask_data;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compare every cycle at the falling edge
    always @(negedge clk) if (!rst) begin
        logic pend, exp_oe, exp_drv;
        pend = ie && ((m_flags & m_mask) != 0);
        if (mode_edge) begin
            exp_oe = 1;
            exp_drv = (ie && m_cnt > 0) ? pol_high : ~pol_high;
        end else begin
            exp_oe = pend; exp_drv = 0;
        end
        chk("R2/R3/R4 flags", flags, m_flags);
        chk("R7/R8/R10 oe", pin_oe, exp_oe);
        if (exp_oe) chk("R7/R9 drv", pin_drv, exp_drv);
    end

    task automatic cyc(int n = 1);
        repeat (n) @(posedge clk);
        #1;
        evt_pulse = 0; clr_we = 0; mask_we = 0;
    endtask

    initial begin
        int cnt;
        repeat (2) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk("R1 flags reset", flags, 0);
        chk("R1 oe reset", pin_oe, 0);
        // R2/R5: suspend bit 7 and in0 bit 0
        evt_pulse = 8'h81; cyc();
        @(negedge clk); chk("R5 bit order", flags, 8'h81);
        // R7: masked out -> no drive; R6
        ie = 1; cyc();
        @(negedge clk); chk("R6 masked out", pin_oe, 0);
        mask_data = 8'h01; mask_we = 1; cyc();
        @(negedge clk); chk("R7 level low", {pin_oe, pin_drv}, 2'b10);
        // R10: ie clear releases
        ie = 0; cyc();
        @(negedge clk); chk("R10 level released", pin_oe, 0);
        ie = 1;
        // R3: clear bit 0 only
        clr_data = 8'h01; clr_we = 1; cyc();
        @(negedge clk); chk("R3 partial clear", flags, 8'h80);
        // R4: set & clear same cycle
        evt_pulse = 8'h04; clr_data = 8'h04; clr_we = 1; cyc();
        @(negedge clk); chk("R4 set wins", flags[2], 1);
        clr_data = 8'hFF; clr_we = 1; cyc();
        // R9: edge mode, pulse length
        mode_edge = 1; pol_high = 1; mask_data = 8'h06; mask_we = 1; cyc(2);
        @(negedge clk); chk("R8 idle inactive", pin_drv, 0);
        evt_pulse = 8'h02; cyc();
        cnt = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); if (pin_drv) cnt++;
            if (k == 2) evt_pulse = 8'h04; // second flag, no new pulse
        end
        chk("R9 pulse length 4", cnt, 4);
        // R10 edge: ie=0 hold inactive with low polarity
        clr_data = 8'hFF; clr_we = 1; cyc();
        pol_high = 0; ie = 0; evt_pulse = 8'h02; cyc(3);
        @(negedge clk); chk("R10 edge inactive", {pin_oe, pin_drv}, 2'b11);
        cyc(10);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule